// File: doc/BRIEF.md
# Dual-Speed Audio Clock Divider Tree

This block turns one master clock, running at 512 times the single-speed audio sample rate (22.5792 MHz for the 44.1 kHz family, 24.576 MHz for the 48 kHz family), into the audio timing signals of a system. It produces four outputs:

- a 256fs rate enable;
- an active-low 64fs bit clock;
- an active-low frame clock;
- a separately registered word-clock output.

All four come from one free-running binary phase counter, so every edge sits on a known master-clock count.

A speed input selects single-speed or double-speed operation. The master clock frequency stays the same in both modes. The divide ratios halve in double speed, so the bit clock and frame clock run twice as fast. A change of speed is held back until the counter wraps, so no output ever shows a shortened pulse. The 256fs output is a one-cycle enable rather than a derived clock. In double speed its rate equals the master clock, so the enable is held high.

Top module: `audio_clk_divtree`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) restarts the phase count at 0. After any edge that samples reset, the outputs are idle: `rate_en_o`=0, `bclk_n_o`=1, `fclk_n_o`=1, `wclk_o`=1.
- R2: In single speed, `rate_en_o` is 1 on odd phase counts and 0 on even counts, so it is high on every second master cycle.
- R3: In single speed, `bclk_n_o` has a period of 8 master cycles. It is low for phase counts 0 to 3 and high for counts 4 to 7 of each group of eight.
- R4: In single speed, `fclk_n_o` has a period of 512 master cycles. It is high for phase counts 0 to 255 and low for counts 256 to 511.
- R5: In double speed, `rate_en_o` is 1 on every master cycle.
- R6: In double speed, `bclk_n_o` has a period of 4 master cycles. It is low for counts 0 to 1 and high for counts 2 to 3, counted modulo 4.
- R7: In double speed, `fclk_n_o` has a period of 256 master cycles. It is high for counts 0 to 127 and low for counts 128 to 255, counted modulo 256.
- R8: `wclk_o` always shows the same level as `fclk_n_o`.
- R9: Every falling edge of `fclk_n_o` falls in the same cycle as a falling edge of `bclk_n_o`.
- R10: The phase count starts at 0 after reset and advances by one on every master edge, wrapping from 511 to 0.
  - `speed_i` (0 = single, 1 = double) is sampled at the reset edge and at the edge where the count wraps to 0.
  - A change of `speed_i` at any other time has no effect until the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 512x the single-speed sample rate |
| rst_i | input | 1 | Synchronous active-high reset |
| speed_i | input | 1 | Speed request: 0 single, 1 double |
| rate_en_o | output | 1 | 256fs enable, one master cycle wide |
| bclk_n_o | output | 1 | 64fs bit clock, active low |
| fclk_n_o | output | 1 | Frame clock at fs, active low |
| wclk_o | output | 1 | Buffered word-clock output at fs |

## Verification
The bench builds the block with its default parameters: a 9-bit phase counter, a 256fs enable at half the master rate, and a bit clock at one eighth of the master rate. With these values a whole 512-count frame and several wraps fit in a few thousand cycles. Speed requests are raised mid-frame in both directions, and reset is applied in the middle of a frame while double speed is requested. This makes the deferred handover, the restart of the phase count and the choice of speed at reset directly observable at the outputs.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   typedef enum logic {
      SPEED_SINGLE = 1'b0,
      SPEED_DOUBLE = 1'b1
   } speed_e;

   // Output levels driven while reset is applied.
   localparam logic IDLE_RATE_EN = 1'b0;
   localparam logic IDLE_BCLK_N  = 1'b1;
   localparam logic IDLE_FCLK_N  = 1'b1;
   localparam logic IDLE_WCLK    = 1'b1;

endpackage

// File: rtl/cdt_phase_counter.sv
module cdt_phase_counter #(
   parameter int CNT_W = 9
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               speed_i,
   output logic [CNT_W-1:0]   cnt_nxt_o,
   output cdt_pkg::speed_e    speed_nxt_o,
   output cdt_pkg::speed_e    speed_q_o
);
   import cdt_pkg::*;

   localparam logic [CNT_W-1:0] CNT_LAST = '1;

   logic [CNT_W-1:0] cnt_q;
   speed_e           speed_q;
   logic             wrap_w;

   generate
      if (CNT_W < 3) begin : g_bad_width
         $error("cdt_phase_counter: CNT_W must be at least 3");
      end
   endgenerate

   assign wrap_w = (cnt_q == CNT_LAST);

   always_comb begin
      if (rst_i) begin
         cnt_nxt_o   = '0;
         speed_nxt_o = speed_e'(speed_i);
      end else begin
         cnt_nxt_o   = cnt_q + 1'b1;
         speed_nxt_o = wrap_w ? speed_e'(speed_i) : speed_q;
      end
   end

   always_ff @(posedge clk_i) begin
      cnt_q   <= cnt_nxt_o;
      speed_q <= speed_nxt_o;
   end

   assign speed_q_o = speed_q;

   // R10: the phase count steps by exactly one each edge outside reset
   assert_count_step_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (cnt_q == $past(cnt_q) + 1'b1));

   // R10: a new speed is latched only as the count lands on zero
   assert_speed_at_wrap_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && (speed_q != $past(speed_q))) |-> (cnt_q == '0));

   // R1: the first count after reset is zero
   assert_count_restart_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (cnt_q == '0));

endmodule

// File: rtl/cdt_tap_mux.sv
module cdt_tap_mux #(
   parameter bit INVERT = 1'b0
) (
   input  logic            single_bit_i,
   input  logic            double_bit_i,
   input  cdt_pkg::speed_e speed_i,
   output logic            tap_o
);
   import cdt_pkg::*;

   logic sel_w;

   assign sel_w = (speed_i == SPEED_DOUBLE) ? double_bit_i : single_bit_i;

   generate
      if (INVERT) begin : g_inv
         assign tap_o = ~sel_w;
      end else begin : g_pass
         assign tap_o = sel_w;
      end
   endgenerate

endmodule

// File: rtl/cdt_rate_enable.sv
module cdt_rate_enable #(
   parameter int MCK_LOG2 = 1
) (
   input  logic [MCK_LOG2-1:0] low_bits_i,
   input  cdt_pkg::speed_e     speed_i,
   output logic                en_o
);
   import cdt_pkg::*;

   logic single_en_w;
   logic double_en_w;

   assign single_en_w = &low_bits_i;

   generate
      if (MCK_LOG2 == 1) begin : g_every_cycle
         assign double_en_w = 1'b1;
      end else begin : g_divided
         assign double_en_w = &low_bits_i[MCK_LOG2-2:0];
      end
   endgenerate

   assign en_o = (speed_i == SPEED_DOUBLE) ? double_en_w : single_en_w;

endmodule

// File: rtl/audio_clk_divtree.sv
module audio_clk_divtree #(
   parameter int RATIO_LOG2 = 9,  // log2(master / single-speed fs)
   parameter int BCK_LOG2   = 3,  // log2(master / single-speed 64fs)
   parameter int MCK_LOG2   = 1   // log2(master / single-speed 256fs)
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic speed_i,
   output logic rate_en_o,
   output logic bclk_n_o,
   output logic fclk_n_o,
   output logic wclk_o
);
   import cdt_pkg::*;

   localparam int CNT_W        = RATIO_LOG2;
   localparam int BCK_TAP_SGL  = BCK_LOG2 - 1;
   localparam int BCK_TAP_DBL  = BCK_LOG2 - 2;
   localparam int FRM_TAP_SGL  = RATIO_LOG2 - 1;
   localparam int FRM_TAP_DBL  = RATIO_LOG2 - 2;

   generate
      if (MCK_LOG2 < 1) begin : g_bad_mck
         $error("audio_clk_divtree: MCK_LOG2 must be at least 1");
      end
      if (BCK_LOG2 < 2 || BCK_LOG2 <= MCK_LOG2) begin : g_bad_bck
         $error("audio_clk_divtree: BCK_LOG2 must be at least 2 and above MCK_LOG2");
      end
      if (RATIO_LOG2 <= BCK_LOG2) begin : g_bad_ratio
         $error("audio_clk_divtree: RATIO_LOG2 must exceed BCK_LOG2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_nxt_w;
   speed_e           speed_nxt_w;
   speed_e           speed_q_w;
   logic             rate_en_w;
   logic             bclk_n_w;
   logic             fclk_n_w;
   logic             wclk_w;

   cdt_phase_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .speed_i     (speed_i),
      .cnt_nxt_o   (cnt_nxt_w),
      .speed_nxt_o (speed_nxt_w),
      .speed_q_o   (speed_q_w)
   );

   cdt_rate_enable #(.MCK_LOG2(MCK_LOG2)) u_rate_en (
      .low_bits_i (cnt_nxt_w[MCK_LOG2-1:0]),
      .speed_i    (speed_nxt_w),
      .en_o       (rate_en_w)
   );

   // Bit clock: low in the first half of each bit period, so its fall
   // coincides with the frame clock's mid-frame fall.
   cdt_tap_mux #(.INVERT(1'b0)) u_bclk (
      .single_bit_i (cnt_nxt_w[BCK_TAP_SGL]),
      .double_bit_i (cnt_nxt_w[BCK_TAP_DBL]),
      .speed_i      (speed_nxt_w),
      .tap_o        (bclk_n_w)
   );

   cdt_tap_mux #(.INVERT(1'b1)) u_fclk (
      .single_bit_i (cnt_nxt_w[FRM_TAP_SGL]),
      .double_bit_i (cnt_nxt_w[FRM_TAP_DBL]),
      .speed_i      (speed_nxt_w),
      .tap_o        (fclk_n_w)
   );

   cdt_tap_mux #(.INVERT(1'b1)) u_wclk (
      .single_bit_i (cnt_nxt_w[FRM_TAP_SGL]),
      .double_bit_i (cnt_nxt_w[FRM_TAP_DBL]),
      .speed_i      (speed_nxt_w),
      .tap_o        (wclk_w)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rate_en_o <= IDLE_RATE_EN;
         bclk_n_o  <= IDLE_BCLK_N;
         fclk_n_o  <= IDLE_FCLK_N;
         wclk_o    <= IDLE_WCLK;
      end else begin
         rate_en_o <= rate_en_w;
         bclk_n_o  <= bclk_n_w;
         fclk_n_o  <= fclk_n_w;
         wclk_o    <= wclk_w;
      end
   end

   assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (!rate_en_o && bclk_n_o && fclk_n_o && wclk_o));

   assert_double_rate_en_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && (MCK_LOG2 == 1) && (speed_q_w == SPEED_DOUBLE)) |-> rate_en_o);

   assert_single_rate_toggle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && (MCK_LOG2 == 1) && (speed_q_w == SPEED_SINGLE)
       && ($past(speed_q_w) == SPEED_SINGLE)) |-> (rate_en_o != $past(rate_en_o)));

   assert_frame_edge_aligned_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(fclk_n_o) |-> $fell(bclk_n_o));

   assert_word_follows_frame_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (wclk_o == fclk_n_o));

   // R4: a frame starts with the frame and word clocks high
   assert_frame_start_high_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && ($past(cnt_nxt_w) == '0)) |-> (fclk_n_o && wclk_o));

endmodule

// File: tb/audio_clk_divtree_tb_top.sv
module audio_clk_divtree_tb_top;

   typedef struct packed {
      logic in_rst;
      logic mode;
      logic pend;
      logic mck;
      logic bck;
      logic frm;
      logic wck;
   } exp_t;

   logic clk = 1'b0;
   logic rst_i = 1'b1;
   logic speed_i = 1'b0;
   logic rate_en_o, bclk_n_o, fclk_n_o, wclk_o;

   int n_cmp = 0;
   int n_bad = 0;
   exp_t exp_q[$];

   int   m_cnt = 0;
   logic m_mode = 1'b0;
   logic prev_frm = 1'b1;
   logic prev_bck = 1'b1;

   always #2.5 clk = ~clk;

   audio_clk_divtree dut_i (
      .clk_i     (clk),
      .rst_i     (rst_i),
      .speed_i   (speed_i),
      .rate_en_o (rate_en_o),
      .bclk_n_o  (bclk_n_o),
      .fclk_n_o  (fclk_n_o),
      .wclk_o    (wclk_o)
   );

   // Reference model: expected outputs after each rising edge.
   always @(posedge clk) begin
      exp_t e;
      if (rst_i) begin
         m_cnt  = 0;
         m_mode = speed_i;
         e.mck = 1'b0; e.bck = 1'b1; e.frm = 1'b1; e.wck = 1'b1;
         e.in_rst = 1'b1;
      end else begin
         m_cnt = (m_cnt + 1) % 512;
         if (m_cnt == 0) m_mode = speed_i;
         e.in_rst = 1'b0;
         if (!m_mode) begin
            e.mck = (m_cnt % 2) == 1;
            e.bck = (m_cnt % 8) >= 4;
            e.frm = m_cnt < 256;
         end else begin
            e.mck = 1'b1;
            e.bck = (m_cnt % 4) >= 2;
            e.frm = (m_cnt % 256) < 128;
         end
         e.wck = e.frm;
      end
      e.mode = m_mode;
      e.pend = (speed_i != m_mode);
      exp_q.push_back(e);
   end

   task automatic check(input string req, input string what, input logic act, input logic expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, expv, $time);
      end
   endtask

   // Monitor: pops expected items and compares away from the rising edge.
   always @(negedge clk) begin
      exp_t e;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         if (e.in_rst) begin
            check("R1", "rate_en", rate_en_o, e.mck);
            check("R1", "bclk_n", bclk_n_o, e.bck);
            check("R1", "fclk_n", fclk_n_o, e.frm);
            check("R1", "wclk", wclk_o, e.wck);
         end else begin
            check(e.mode ? "R5" : "R2", "rate_en", rate_en_o, e.mck);
            check(e.pend ? "R10" : (e.mode ? "R6" : "R3"), "bclk_n", bclk_n_o, e.bck);
            check(e.mode ? "R7" : "R4", "fclk_n", fclk_n_o, e.frm);
            check("R8", "wclk", wclk_o, e.wck);
            if (prev_frm && !fclk_n_o) begin
               check("R9", "bclk_n fall with frame fall", prev_bck && !bclk_n_o, 1'b1);
            end
         end
         prev_frm = fclk_n_o;
         prev_bck = bclk_n_o;
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      run(3);
      rst_i = 1'b0;
      run(300);
      speed_i = 1'b1;     // R10: mid-frame request, held until wrap at 512
      run(700);
      run(100);
      speed_i = 1'b0;     // back to single at the next wrap
      run(600);
      run(200);
      speed_i = 1'b1;     // R1: reset mid-frame with double speed requested
      rst_i = 1'b1;
      run(2);
      rst_i = 1'b0;
      run(700);
      speed_i = 1'b0;
      run(600);
      run(2);
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule